// File: doc/BRIEF.md
# Register Rename Unit

This block turns architectural register names into physical register tags, one instruction per cycle, so that later writers of a register no longer collide with earlier readers or writers of the same name. It keeps a map table with one entry per architectural register, giving that register's newest physical version. It also keeps a circular queue of physical tags that are currently unused.

A decode port presents two source names and an optional destination name. The source tags and the destination's previous tag are looked up combinationally from the current map. When a destination is wanted, the tag at the head of the free queue becomes its new version. The old tag is handed out so the retire logic can release it later. A release port appends one tag per cycle to the free queue. A snapshot input saves the map and the free-queue read pointer, and a restore input brings both back in one cycle when speculative work is thrown away. There are always more physical than architectural registers.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, every architectural register i reads back as physical tag i on both source outputs.
- R2: After reset, the free queue holds the tags ARCH_REGS up to PHYS_REGS-1, and they are handed out in ascending order.
- R3: Sources and the previous destination tag are read from the map as it stands before this instruction's own remap, so an instruction whose source equals its destination sees the older tag on both `out_psrc*` and `out_pold`.
- R4: A destination remap done in one cycle is seen by lookups in every following cycle until that register is remapped again or a restore occurs.
- R5: An instruction with `dec_dst_en` low takes no tag and leaves the map unchanged. The next allocation still yields the same head tag.
- R6: `dec_stall` is high exactly when `dec_valid` and `dec_dst_en` are high and the free queue is empty. A stalled decode changes neither the map nor the queue. A release in the same cycle does not lift the stall.
- R7: A tag given to `cmt_valid`/`cmt_tag` joins the tail of the free queue, and tags are reused in first-in, first-out order.
- R8: An allocation and a release in the same cycle both take effect.
- R9: `ckpt_take` saves the map and free-queue head as they stand at the start of that cycle. `restore_valid` puts both back in one cycle, and tags released since the snapshot stay free.
- R10: A decode presented in a restore cycle has no effect on the map or on the free queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction is presented for renaming |
| dec_src0 | input | clog2(ARCH_REGS) | First source architectural register |
| dec_src1 | input | clog2(ARCH_REGS) | Second source architectural register |
| dec_dst_en | input | 1 | Instruction writes a register |
| dec_dst | input | clog2(ARCH_REGS) | Destination architectural register |
| out_psrc0 | output | clog2(PHYS_REGS) | Physical tag of first source |
| out_psrc1 | output | clog2(PHYS_REGS) | Physical tag of second source |
| out_pdst | output | clog2(PHYS_REGS) | New physical tag for the destination |
| out_pold | output | clog2(PHYS_REGS) | Destination's tag before this remap |
| dec_stall | output | 1 | Decode must hold: no free tag |
| cmt_valid | input | 1 | Release one physical tag |
| cmt_tag | input | clog2(PHYS_REGS) | Tag being released |
| ckpt_take | input | 1 | Save map and free-queue head |
| restore_valid | input | 1 | Return to the saved state |

## Verification
All decode outputs and the stall flag are combinational in the cycle the instruction is presented. Every change to the map or the free queue shows up in lookups from the next cycle on. The bench drives each instruction just after a falling edge and samples the outputs 2 ns later, still before the rising edge that commits the change. The effect of that edge is then checked on the following instruction. A reference map and a queue model, updated once per driven cycle, supply the expected tags for each scoreboard entry.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // Operation applied to the free queue pointers in a cycle
  typedef enum logic [1:0] {
    FQ_HOLD = 2'b00,
    FQ_TAKE = 2'b01,
    FQ_GIVE = 2'b10,
    FQ_BOTH = 2'b11
  } fq_op_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(ARCH_REGS)-1:0] rd_a0,
  input  logic [$clog2(ARCH_REGS)-1:0] rd_a1,
  input  logic [$clog2(ARCH_REGS)-1:0] rd_a2,
  output logic [$clog2(PHYS_REGS)-1:0] rd_d0,
  output logic [$clog2(PHYS_REGS)-1:0] rd_d1,
  output logic [$clog2(PHYS_REGS)-1:0] rd_d2,
  input  logic                         wr_en,
  input  logic [$clog2(ARCH_REGS)-1:0] wr_addr,
  input  logic [$clog2(PHYS_REGS)-1:0] wr_data,
  input  logic                         snap_en,
  input  logic                         back_en
);
  localparam int AW = $clog2(ARCH_REGS);
  localparam int PW = $clog2(PHYS_REGS);

  logic [PW-1:0] map_q  [ARCH_REGS];
  logic [PW-1:0] map_d  [ARCH_REGS];
  logic [PW-1:0] snap_q [ARCH_REGS];
  logic [PW-1:0] snap_d [ARCH_REGS];

  // reads see the map before this cycle's write
  assign rd_d0 = map_q[rd_a0];
  assign rd_d1 = map_q[rd_a1];
  assign rd_d2 = map_q[rd_a2];

  generate
    for (genvar g = 0; g < ARCH_REGS; g++) begin : g_entry
      always_comb begin
        map_d[g]  = map_q[g];
        snap_d[g] = snap_q[g];
        if (back_en) begin
          map_d[g] = snap_q[g];
        end else begin
          if (wr_en && (wr_addr == AW'(g))) map_d[g] = wr_data;
          if (snap_en) snap_d[g] = map_q[g];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          map_q[g]  <= PW'(g);
          snap_q[g] <= PW'(g);
        end else begin
          map_q[g]  <= map_d[g];
          snap_q[g] <= snap_d[g];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rn_free_queue.sv
module rn_free_queue
  import rn_pkg::*;
#(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         take,
  input  logic                         give,
  input  logic [$clog2(PHYS_REGS)-1:0] give_tag,
  input  logic                         snap_en,
  input  logic                         back_en,
  output logic [$clog2(PHYS_REGS)-1:0] head_tag,
  output logic                         empty
);
  localparam int PW    = $clog2(PHYS_REGS);
  localparam int DEPTH = 1 << PW;
  localparam int NFREE = PHYS_REGS - ARCH_REGS;

  logic [PW-1:0] slot_q [DEPTH];
  logic [PW:0]   head_q, head_d;
  logic [PW:0]   tail_q, tail_d;
  logic [PW:0]   snap_head_q, snap_head_d;
  fq_op_e        op;

  assign op       = fq_op_e'({give, take});
  assign empty    = (head_q == tail_q);
  assign head_tag = slot_q[head_q[PW-1:0]];

  always_comb begin
    head_d      = head_q;
    tail_d      = tail_q;
    snap_head_d = snap_head_q;
    unique case (op)
      FQ_TAKE: head_d = head_q + 1'b1;
      FQ_GIVE: tail_d = tail_q + 1'b1;
      FQ_BOTH: begin
        head_d = head_q + 1'b1;
        tail_d = tail_q + 1'b1;
      end
      default: ;
    endcase
    if (back_en)      head_d      = snap_head_q;
    else if (snap_en) snap_head_d = head_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q      <= '0;
      tail_q      <= (PW+1)'(NFREE);
      snap_head_q <= '0;
    end else begin
      head_q      <= head_d;
      tail_q      <= tail_d;
      snap_head_q <= snap_head_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_q[g] <= (g < NFREE) ? PW'(ARCH_REGS + g) : '0;
        end else if (give && (tail_q[PW-1:0] == PW'(g))) begin
          slot_q[g] <= give_tag;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         dec_valid,
  input  logic [$clog2(ARCH_REGS)-1:0] dec_src0,
  input  logic [$clog2(ARCH_REGS)-1:0] dec_src1,
  input  logic                         dec_dst_en,
  input  logic [$clog2(ARCH_REGS)-1:0] dec_dst,
  output logic [$clog2(PHYS_REGS)-1:0] out_psrc0,
  output logic [$clog2(PHYS_REGS)-1:0] out_psrc1,
  output logic [$clog2(PHYS_REGS)-1:0] out_pdst,
  output logic [$clog2(PHYS_REGS)-1:0] out_pold,
  output logic                         dec_stall,
  input  logic                         cmt_valid,
  input  logic [$clog2(PHYS_REGS)-1:0] cmt_tag,
  input  logic                         ckpt_take,
  input  logic                         restore_valid
);
  logic fq_empty;
  logic dst_fire;
  logic wants_dst;

  assign wants_dst = dec_valid & dec_dst_en;
  assign dec_stall = wants_dst & fq_empty;
  assign dst_fire  = wants_dst & ~fq_empty & ~restore_valid;

  rn_map_table #(
    .ARCH_REGS(ARCH_REGS),
    .PHYS_REGS(PHYS_REGS)
  ) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_a0   (dec_src0),
    .rd_a1   (dec_src1),
    .rd_a2   (dec_dst),
    .rd_d0   (out_psrc0),
    .rd_d1   (out_psrc1),
    .rd_d2   (out_pold),
    .wr_en   (dst_fire),
    .wr_addr (dec_dst),
    .wr_data (out_pdst),
    .snap_en (ckpt_take),
    .back_en (restore_valid)
  );

  rn_free_queue #(
    .ARCH_REGS(ARCH_REGS),
    .PHYS_REGS(PHYS_REGS)
  ) u_fq (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (dst_fire),
    .give     (cmt_valid),
    .give_tag (cmt_tag),
    .snap_en  (ckpt_take),
    .back_en  (restore_valid),
    .head_tag (out_pdst),
    .empty    (fq_empty)
  );
endmodule

// File: rtl/rn_rename_checker.sv
module rn_rename_checker #(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 24
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         dec_valid,
  input logic                         dec_dst_en,
  input logic [$clog2(ARCH_REGS)-1:0] dec_src0,
  input logic [$clog2(ARCH_REGS)-1:0] dec_dst,
  input logic [$clog2(PHYS_REGS)-1:0] out_psrc0,
  input logic [$clog2(PHYS_REGS)-1:0] out_pdst,
  input logic [$clog2(PHYS_REGS)-1:0] out_pold,
  input logic                         dec_stall,
  input logic                         dst_fire,
  input logic                         fq_empty,
  input logic                         restore_valid
);
  p_stall_needs_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |-> (dec_valid && dec_dst_en && fq_empty));

  p_fresh_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dst_fire |-> (out_pdst != out_pold));

  p_remap_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dst_fire) && !$past(restore_valid) && (dec_src0 == $past(dec_dst)))
      |-> (out_psrc0 == $past(out_pdst)));

  p_head_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!dst_fire) && $past(!restore_valid) && $past(!fq_empty))
      |-> (out_pdst == $past(out_pdst)));

  p_tag_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fq_empty |-> (32'(out_pdst) < PHYS_REGS));
endmodule

bind rn_rename_unit rn_rename_checker #(
  .ARCH_REGS(ARCH_REGS),
  .PHYS_REGS(PHYS_REGS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dec_valid     (dec_valid),
  .dec_dst_en    (dec_dst_en),
  .dec_src0      (dec_src0),
  .dec_dst       (dec_dst),
  .out_psrc0     (out_psrc0),
  .out_pdst      (out_pdst),
  .out_pold      (out_pold),
  .dec_stall     (dec_stall),
  .dst_fire      (dst_fire),
  .fq_empty      (fq_empty),
  .restore_valid (restore_valid)
);

// File: tb/sim_rn_rename_unit.sv
module sim_rn_rename_unit;
  localparam int ARCH = 16;
  localparam int PHYS = 24;
  localparam int AW   = $clog2(ARCH);
  localparam int PW   = $clog2(PHYS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dec_valid, dec_dst_en, cmt_valid, ckpt_take, restore_valid;
  logic [AW-1:0] dec_src0, dec_src1, dec_dst;
  logic [PW-1:0] cmt_tag;
  logic [PW-1:0] out_psrc0, out_psrc1, out_pdst, out_pold;
  logic          dec_stall;

  always #4 clk = ~clk;

  rn_rename_unit #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_src0(dec_src0), .dec_src1(dec_src1),
    .dec_dst_en(dec_dst_en), .dec_dst(dec_dst),
    .out_psrc0(out_psrc0), .out_psrc1(out_psrc1), .out_pdst(out_pdst),
    .out_pold(out_pold), .dec_stall(dec_stall),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
    .ckpt_take(ckpt_take), .restore_valid(restore_valid)
  );

  typedef struct {
    string         req;
    bit            chk_src;
    bit            chk_dst;
    logic [PW-1:0] s0, s1, d, old;
    logic          stall;
  } exp_t;

  exp_t          exp_q[$];
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;
  logic [PW-1:0] m_map [ARCH];
  logic [PW-1:0] c_map [ARCH];
  logic [PW-1:0] fq[$];
  logic [PW-1:0] cq[$];
  logic [PW-1:0] rq[$];

  task automatic check(string req, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: present one cycle of stimulus, queue what the outputs must be
  task automatic step(string req, bit v, int s0, int s1, bit de, int d,
                      bit cv, int ct, bit tk, bit rs);
    exp_t e;
    @(negedge clk);
    dec_valid = v; dec_src0 = AW'(s0); dec_src1 = AW'(s1);
    dec_dst_en = de; dec_dst = AW'(d);
    cmt_valid = cv; cmt_tag = PW'(ct); ckpt_take = tk; restore_valid = rs;
    e.req     = req;
    e.chk_src = v && !rs;
    e.s0      = m_map[s0];
    e.s1      = m_map[s1];
    e.stall   = v && de && (fq.size() == 0);
    e.chk_dst = v && de && !e.stall && !rs;
    e.d       = e.chk_dst ? fq[0] : '0;
    e.old     = m_map[d];
    exp_q.push_back(e);
    if (rs) begin
      if (cv) rq.push_back(PW'(ct));
      m_map = c_map;
      fq = {cq, rq};
    end else begin
      if (tk) begin
        c_map = m_map;
        cq = fq;
        rq.delete();
      end
      if (e.chk_dst) begin
        void'(fq.pop_front());
        m_map[d] = e.d;
      end
      if (cv) begin
        fq.push_back(PW'(ct));
        rq.push_back(PW'(ct));
      end
    end
  endtask

  // monitor: sample away from the rising edge and compare
  always @(negedge clk) begin
    exp_t e;
    #2;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check(e.req, "stall", PW'(dec_stall), PW'(e.stall));
      if (e.chk_src) begin
        check(e.req, "psrc0", out_psrc0, e.s0);
        check(e.req, "psrc1", out_psrc1, e.s1);
      end
      if (e.chk_dst) begin
        check(e.req, "pdst", out_pdst, e.d);
        check(e.req, "pold", out_pold, e.old);
      end
    end
  end

  initial begin
    repeat (25000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ARCH; i++) begin
      m_map[i] = PW'(i);
      c_map[i] = PW'(i);
    end
    for (int i = ARCH; i < PHYS; i++) fq.push_back(PW'(i));
    cq = fq;
    rst_n = 1'b0;
    dec_valid = 0; dec_dst_en = 0; cmt_valid = 0; ckpt_take = 0; restore_valid = 0;
    dec_src0 = '0; dec_src1 = '0; dec_dst = '0; cmt_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 identity map after reset
    step("R1", 1, 0, 15, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 5, 9, 0, 0, 0, 0, 0, 0);
    // R3 source equal to destination sees the old tag; R2 first tag is 16
    step("R3", 1, 3, 3, 1, 3, 0, 0, 0, 0);
    // R4 the remap is visible on the next lookup
    step("R4", 1, 3, 2, 1, 3, 0, 0, 0, 0);
    // R5 no destination: no tag taken, map untouched
    step("R5", 1, 7, 7, 0, 7, 0, 0, 0, 0);
    step("R5", 1, 7, 3, 1, 8, 0, 0, 0, 0);
    // R9 snapshot, speculative renames, restore
    step("R9", 1, 8, 0, 1, 9, 0, 0, 1, 0);
    step("R9", 1, 9, 1, 1, 1, 0, 0, 0, 0);
    step("R10", 1, 1, 9, 1, 2, 0, 0, 0, 1);
    step("R9", 1, 9, 1, 1, 4, 0, 0, 0, 0);
    step("R10", 1, 2, 1, 0, 0, 0, 0, 0, 0);
    // R2 drain the remaining tags in order
    for (int i = 0; i < 4; i++) step("R2", 1, i, i + 4, 1, 10 + i, 0, 0, 0, 0);
    // R6 empty queue stalls a writer, not a non-writer
    step("R6", 1, 10, 11, 1, 14, 0, 0, 0, 0);
    step("R6", 1, 14, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 1, 0, 0, 1, 14, 1, 3, 0, 0);
    // R8 take and give in the same cycle
    step("R8", 1, 14, 0, 1, 14, 1, 16, 0, 0);
    // R7 released tags come back in FIFO order
    step("R7", 1, 14, 0, 1, 15, 1, 17, 0, 0);
    step("R7", 1, 15, 14, 1, 5, 0, 0, 0, 0);
    step("R6", 1, 5, 15, 1, 6, 0, 0, 0, 0);
    step("R7", 1, 5, 6, 0, 0, 0, 0, 0, 0);
    step("idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule